// File: doc/BRIEF.md
# Raster Timing Generator

This block drives the timing side of a display transmitter. It counts pixel clocks across each line and lines across each frame. From those counts it produces horizontal sync, vertical sync, a data-enable strobe and the coordinates of the active pixel being sent. All outputs come from registers clocked by the pixel clock.

Software programs the raster through a small register-write port. Each write lands in a shadow copy. When the generator is stopped, the shadow is copied to the working set on every clock, so a new setup starts cleanly. While it runs, the copy happens only on the clock where the raster wraps from the last position of a frame back to the first. A frame is therefore never drawn with a mix of old and new timing.

Per-frame control selects interlaced scan, in which odd fields move the vertical sync by half a line. It also selects 2x pixel repetition, in which the horizontal values are supplied already doubled and the reported column is halved. A transmitter-mode flag is passed through to a neighbour that decodes it.

Top module: `raster_timing_gen`

## Requirements
- R1: During and after reset, de, x_pos, y_pos, field_odd and hdmi_mode are 0, and hsync and vsync are 1 (the inactive level for active-low sync).
- R2: Timing registers hold each count minus one, with the vertical value in bits 31:16 and the horizontal value in bits 15:0. The addresses are 1 for active size, 2 for front porch, 3 for sync width and 4 for back porch. Back porch is measured from the start of sync to the end of the line or frame. A line is laid out as active, then front porch, then sync, then the remainder of the back porch. Raster position 0 reaches the outputs two clocks after the write that enables video.
- R3: de is 1 only when both counters lie inside the active region. x_pos and y_pos give the active column and row while de is 1, and are 0 otherwise.
- R4: The polarity register at address 5 makes vsync active-high when bit 1 is set and hsync active-high when bit 0 is set. A clear bit makes that sync active-low.
- R5: A write made while video runs changes nothing until the next frame wrap. From that wrap on, the new value applies.
- R6: The control register is at address 0, and bit 31 enables video. While video is disabled, de is 0, the positions are 0 and both syncs sit at their inactive level. When software clears bit 31 during a frame, that frame completes first.
- R7: Control bit 4 selects interlaced scan. The field flag flips at every frame wrap. In odd fields, vsync starts and ends half a line (line total divided by two, rounded down) later than in even fields.
- R8: Control bit 0 selects 2x repetition. The horizontal values are given doubled, and x_pos reports the pixel counter divided by two.
- R9: Control bit 30 appears on hdmi_mode once the working set holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Active-pixel strobe |
| x_pos | output | 16 | Active column |
| y_pos | output | 16 | Active row |
| field_odd | output | 1 | 1 during odd interlaced fields |
| hdmi_mode | output | 1 | Transmitter-mode flag from control bit 30 |

## Verification
When a write takes effect while the generator is idle, it reaches the working set one clock later. Its effect reaches the outputs one clock after that, so the first raster position, a new idle polarity and the mode flag are all due two clocks after the write. While the generator runs, the working set changes only at a frame wrap. The bench therefore starts a reference raster position two clocks after the enabling write and moves it forward by exactly one position per clock. Every output is compared against that position on the falling edge. Writes made in the middle of a frame enter the model's shadow copy and are applied only at the model's own wrap, which keeps the expected value of each sample aligned to the correct clock.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int FIELD_W    = 16;
    localparam int CNT_W      = FIELD_W + 2;
    localparam int REG_ADDR_W = 3;
    localparam int DATA_W     = 2 * FIELD_W;

    // control word bit positions
    localparam int CTRL_VID_EN = 31;
    localparam int CTRL_HDMI   = 30;
    localparam int CTRL_INTL   = 4;
    localparam int CTRL_REP    = 0;

    // polarity word bit positions
    localparam int POL_VS_HIGH = 1;
    localparam int POL_HS_HIGH = 0;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_ACTIVE = 3'd1,
        SEL_FPORCH = 3'd2,
        SEL_SWIDTH = 3'd3,
        SEL_BPORCH = 3'd4,
        SEL_POL    = 3'd5
    } reg_sel_e;

    // vertical in the upper half, horizontal in the lower half
    typedef struct packed {
        logic [FIELD_W-1:0] v;
        logic [FIELD_W-1:0] h;
    } axis_pair_t;

    typedef struct packed {
        logic       vid_en;
        logic       hdmi;
        logic       intl;
        logic       rep;
        logic       vs_high;
        logic       hs_high;
        axis_pair_t act;
        axis_pair_t fp;
        axis_pair_t sw;
        axis_pair_t bp;
    } timing_set_t;

    typedef struct packed {
        logic               hs;
        logic               vs;
        logic               de;
        logic               fld;
        logic               hdmi;
        logic [FIELD_W-1:0] x;
        logic [FIELD_W-1:0] y;
    } raster_out_t;

    // last counter value of an axis: (a+1)+(f+1)+(b+1)-1
    function automatic logic [CNT_W-1:0] axis_last(input logic [FIELD_W-1:0] a,
                                                   input logic [FIELD_W-1:0] f,
                                                   input logic [FIELD_W-1:0] b);
        return CNT_W'(a) + CNT_W'(f) + CNT_W'(b) + CNT_W'(2);
    endfunction

    // first counter value of the sync pulse on an axis
    function automatic logic [CNT_W-1:0] sync_first(input logic [FIELD_W-1:0] a,
                                                    input logic [FIELD_W-1:0] f);
        return CNT_W'(a) + CNT_W'(f) + CNT_W'(2);
    endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  frame_wrap,
    output timing_set_t           work
);

    timing_set_t shadow;
    logic        commit;

    assign commit = !work.vid_en || frame_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            work   <= '0;
        end else begin
            if (commit) begin
                work <= shadow;
            end
            if (wr_en) begin
                case (wr_addr)
                    SEL_CTRL: begin
                        shadow.vid_en <= wr_data[CTRL_VID_EN];
                        shadow.hdmi   <= wr_data[CTRL_HDMI];
                        shadow.intl   <= wr_data[CTRL_INTL];
                        shadow.rep    <= wr_data[CTRL_REP];
                    end
                    SEL_ACTIVE: shadow.act <= wr_data;
                    SEL_FPORCH: shadow.fp  <= wr_data;
                    SEL_SWIDTH: shadow.sw  <= wr_data;
                    SEL_BPORCH: shadow.bp  <= wr_data;
                    SEL_POL: begin
                        shadow.vs_high <= wr_data[POL_VS_HIGH];
                        shadow.hs_high <= wr_data[POL_HS_HIGH];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: running working set only moves on a frame wrap
    assert_hold_midframe_R5: assert property (@(posedge clk) disable iff (rst)
        (work.vid_en && !frame_wrap) |=> $stable(work));

endmodule

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  timing_set_t      work,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt,
    output logic             field,
    output logic             frame_wrap
);

    logic [CNT_W-1:0] h_last;
    logic [CNT_W-1:0] v_last;
    logic             line_end;

    always_comb begin
        h_last     = axis_last(work.act.h, work.fp.h, work.bp.h);
        v_last     = axis_last(work.act.v, work.fp.v, work.bp.v);
        line_end   = (hcnt == h_last);
        frame_wrap = work.vid_en && line_end && (vcnt == v_last);
    end

    always_ff @(posedge clk) begin
        if (rst || !work.vid_en) begin
            hcnt  <= '0;
            vcnt  <= '0;
            field <= 1'b0;
        end else if (line_end) begin
            hcnt <= '0;
            if (vcnt == v_last) begin
                vcnt  <= '0;
                field <= work.intl ? ~field : 1'b0;
            end else begin
                vcnt <= vcnt + CNT_W'(1);
            end
        end else begin
            hcnt <= hcnt + CNT_W'(1);
        end
    end

    assert_h_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        work.vid_en |-> (hcnt <= h_last));

    assert_wrap_to_origin_R2: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (hcnt == '0 && vcnt == '0));

    assert_field_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (work.vid_en && !frame_wrap) |=> $stable(field));

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  timing_set_t      work,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    input  logic             field,
    output raster_out_t      out_q
);

    logic [CNT_W-1:0] h_act, v_act, hs_beg, hs_end, vs_beg, vs_end, half;
    logic [CNT_W-1:0] col;
    logic             in_act, hs_on, vs_even, vs_odd, vs_on;
    raster_out_t      nxt;

    always_comb begin
        h_act  = CNT_W'(work.act.h) + CNT_W'(1);
        v_act  = CNT_W'(work.act.v) + CNT_W'(1);
        hs_beg = sync_first(work.act.h, work.fp.h);
        vs_beg = sync_first(work.act.v, work.fp.v);
        hs_end = hs_beg + CNT_W'(work.sw.h) + CNT_W'(1);
        vs_end = vs_beg + CNT_W'(work.sw.v) + CNT_W'(1);
        half   = (axis_last(work.act.h, work.fp.h, work.bp.h) + CNT_W'(1)) >> 1;

        in_act  = work.vid_en && (hcnt < h_act) && (vcnt < v_act);
        hs_on   = work.vid_en && (hcnt >= hs_beg) && (hcnt < hs_end);
        vs_even = (vcnt >= vs_beg) && (vcnt < vs_end);
        vs_odd  = ((vcnt > vs_beg) || ((vcnt == vs_beg) && (hcnt >= half))) &&
                  ((vcnt < vs_end) || ((vcnt == vs_end) && (hcnt < half)));
        vs_on   = work.vid_en && (field ? vs_odd : vs_even);
        col     = work.rep ? (hcnt >> 1) : hcnt;

        nxt.hs   = work.hs_high ? hs_on : ~hs_on;
        nxt.vs   = work.vs_high ? vs_on : ~vs_on;
        nxt.de   = in_act;
        nxt.fld  = work.vid_en && field;
        nxt.hdmi = work.hdmi;
        nxt.x    = in_act ? col[FIELD_W-1:0]  : '0;
        nxt.y    = in_act ? vcnt[FIELD_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q    <= '0;
            out_q.hs <= 1'b1;
            out_q.vs <= 1'b1;
        end else begin
            out_q <= nxt;
        end
    end

    // R3/R4: an active pixel never coincides with an asserted hsync
    assert_de_no_hsync_R4: assert property (@(posedge clk) disable iff (rst)
        out_q.de |-> (out_q.hs == !work.hs_high));

    // R6: one clock after an idle working set, outputs rest
    assert_idle_rest_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!work.vid_en) |-> (!out_q.de && out_q.vs == !$past(work.vs_high)
                                 && out_q.hs == !$past(work.hs_high)));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  hsync,
    output logic                  vsync,
    output logic                  de,
    output logic [FIELD_W-1:0]    x_pos,
    output logic [FIELD_W-1:0]    y_pos,
    output logic                  field_odd,
    output logic                  hdmi_mode
);

    timing_set_t      work;
    logic [CNT_W-1:0] hcnt;
    logic [CNT_W-1:0] vcnt;
    logic             field;
    logic             frame_wrap;
    raster_out_t      out_q;

    raster_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .work       (work)
    );

    raster_counter u_count (
        .clk        (clk),
        .rst        (rst),
        .work       (work),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .field      (field),
        .frame_wrap (frame_wrap)
    );

    raster_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .work  (work),
        .hcnt  (hcnt),
        .vcnt  (vcnt),
        .field (field),
        .out_q (out_q)
    );

    assign hsync     = out_q.hs;
    assign vsync     = out_q.vs;
    assign de        = out_q.de;
    assign x_pos     = out_q.x;
    assign y_pos     = out_q.y;
    assign field_odd = out_q.fld;
    assign hdmi_mode = out_q.hdmi;

endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;

    typedef struct {
        bit en, hdmi, il, rep, hpol, vpol;
        int ha, hf, hw, hb, va, vf, vw, vb;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, field_odd, hdmi_mode;
    logic [15:0] x_pos, y_pos;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    cfg_t m_shadow, cfg_a;

    raster_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .de(de), .x_pos(x_pos), .y_pos(y_pos),
        .field_odd(field_odd), .hdmi_mode(hdmi_mode)
    );

    always #10 clk = ~clk;

    function automatic logic [36:0] observe();
        return {hsync, vsync, de, field_odd, hdmi_mode, x_pos, y_pos};
    endfunction

    task automatic check(input bit ok, input string tag, input int k,
                         input logic [36:0] got, input logic [36:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s sample %0d got=%h expected=%h", tag, k, got, exp);
        end
    endtask

    function automatic logic [36:0] expect_at(cfg_t c, int h, int v, bit fld);
        int  htot, vss, vse, half;
        bit  act, hsa, vsa;
        logic [15:0] xx, yy;
        if (!c.en) return {!c.hpol, !c.vpol, 1'b0, 1'b0, c.hdmi, 16'd0, 16'd0};
        htot = c.ha + c.hf + c.hb;
        half = htot / 2;
        vss  = c.va + c.vf;
        vse  = vss + c.vw;
        act  = (h < c.ha) && (v < c.va);
        hsa  = (h >= c.ha + c.hf) && (h < c.ha + c.hf + c.hw);
        if (fld)
            vsa = ((v > vss) || (v == vss && h >= half)) &&
                  ((v < vse) || (v == vse && h < half));
        else
            vsa = (v >= vss) && (v < vse);
        xx = act ? 16'(c.rep ? h / 2 : h) : 16'd0;
        yy = act ? 16'(v) : 16'd0;
        return {c.hpol ? hsa : !hsa, c.vpol ? vsa : !vsa, act, fld, c.hdmi, xx, yy};
    endfunction

    function automatic logic [31:0] pair(int v, int h);
        return {16'(v - 1), 16'(h - 1)};
    endfunction

    function automatic logic [31:0] ctrl_word(cfg_t c);
        logic [31:0] w = '0;
        w[31] = c.en; w[30] = c.hdmi; w[4] = c.il; w[0] = c.rep;
        return w;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_cfg(cfg_t c);
        wr(3'd1, pair(c.va, c.ha));
        wr(3'd2, pair(c.vf, c.hf));
        wr(3'd3, pair(c.vw, c.hw));
        wr(3'd4, pair(c.vb, c.hb));
        wr(3'd5, {30'd0, c.vpol, c.hpol});
        wr(3'd0, ctrl_word(c));
        m_shadow = c;
    endtask

    // position 0 is due at the second falling edge after the enabling write
    task automatic run_samples(input int n, input string tag, input int wk,
                               input logic [2:0] wa, input logic [31:0] wd, input cfg_t nxt);
        cfg_t cur = m_shadow;
        int   mh = 0, mv = 0;
        bit   mfld = 0;
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            check(observe() == expect_at(cur, mh, mv, cur.il && mfld), tag, k,
                  observe(), expect_at(cur, mh, mv, cur.il && mfld));
            if (k == wk) begin
                wr_en = 1'b1; wr_addr = wa; wr_data = wd;
                m_shadow = nxt;
            end
            if (cur.en) begin
                if (mh == cur.ha + cur.hf + cur.hb - 1) begin
                    mh = 0;
                    if (mv == cur.va + cur.vf + cur.vb - 1) begin
                        mv = 0;
                        mfld = cur.il ? !mfld : 1'b0;
                        cur = m_shadow;
                    end else mv++;
                end else mh++;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(observe() == {1'b1, 1'b1, 35'd0}, "R1 reset", 0, observe(), {1'b1, 1'b1, 35'd0});
    endtask

    task automatic t_idle_polarity();
        logic [36:0] e1 = {1'b1, 1'b1, 35'd0};
        logic [36:0] e2 = {1'b0, 1'b0, 35'd0};
        do_reset();
        wr(3'd5, 32'h3);
        @(negedge clk);
        check(observe() == e1, "R6 idle level not yet changed", 0, observe(), e1);
        @(negedge clk);
        check(observe() == e2, "R6 R4 idle level follows polarity", 1, observe(), e2);
    endtask

    task automatic t_progressive();
        do_reset(); load_cfg(cfg_a);
        run_samples(250, "R2 R3 progressive", -1, 3'd0, 32'd0, cfg_a);
    endtask

    task automatic t_polarity();
        cfg_t c = cfg_a;
        c.hpol = 1; c.vpol = 1;
        do_reset(); load_cfg(c);
        run_samples(130, "R4 active-high", -1, 3'd0, 32'd0, c);
    endtask

    task automatic t_interlace();
        cfg_t c = cfg_a;
        c.il = 1;
        do_reset(); load_cfg(c);
        run_samples(370, "R7 interlace", -1, 3'd0, 32'd0, c);
    endtask

    task automatic t_repeat();
        cfg_t c = cfg_a;
        c.rep = 1; c.hdmi = 1;
        c.ha = 16; c.hf = 4; c.hw = 6; c.hb = 10;
        c.va = 3; c.vf = 1; c.vw = 1; c.vb = 2;
        do_reset(); load_cfg(c);
        run_samples(190, "R8 R9 repetition", -1, 3'd0, 32'd0, c);
    endtask

    task automatic t_shadow();
        cfg_t b = cfg_a;
        b.ha = 12;
        do_reset(); load_cfg(cfg_a);
        run_samples(280, "R5 frame-aligned update", 50, 3'd1, pair(4, 12), b);
    endtask

    task automatic t_disable();
        cfg_t d = cfg_a;
        d.en = 0;
        do_reset(); load_cfg(cfg_a);
        run_samples(140, "R6 disable completes frame", 30, 3'd0, ctrl_word(d), d);
    endtask

    initial begin
        cfg_a.en = 1; cfg_a.hdmi = 0; cfg_a.il = 0; cfg_a.rep = 0;
        cfg_a.hpol = 0; cfg_a.vpol = 0;
        cfg_a.ha = 8; cfg_a.hf = 2; cfg_a.hw = 3; cfg_a.hb = 5;
        cfg_a.va = 4; cfg_a.vf = 1; cfg_a.vw = 2; cfg_a.vb = 3;
        @(negedge clk);
        t_reset();
        t_idle_polarity();
        t_progressive();
        t_polarity();
        t_interlace();
        t_repeat();
        t_shadow();
        t_disable();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule